// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides, purely combinationally, whether an instruction may execute. It compares a 4-bit condition code with the four status flags: negative, zero, carry and overflow. It returns a single pass flag that the issue logic uses to commit or squash the instruction.

Two instruction encodings share the unit, and a mode input selects between them. In wide mode the condition sits in the top nibble of a 32-bit word, and every instruction is checked. In narrow mode only the low halfword counts. The only instruction checked there is a conditional branch, recognised by the value 0xD in its top nibble, and it carries its condition one nibble lower. Any other narrow instruction passes unconditionally. For narrow words the block also reports whether the word was a conditional branch.

Top module: `cond_eval`

## Requirements
- R1: With `mode16_i`=0, the code is `instr_i[31:28]`, and `instr_i[27:0]` has no effect on `pass_o`.
- R2: Codes 0 through 7 pass, in that order, when: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0. Flags are packed in `flags_i` as bit 3 N, bit 2 Z, bit 1 C, bit 0 V.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R5: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R6: Codes 14 and 15 pass for every flag value.
- R7: With `mode16_i`=1 and `instr_i[15:12]`=4'hD, `cond_branch_o`=1 and `pass_o` follows the code in `instr_i[11:8]`.
- R8: With `mode16_i`=1 and `instr_i[15:12]`≠4'hD, `pass_o`=1 and `cond_branch_o`=0 for every flag value.
- R9: With `mode16_i`=1, `instr_i[31:16]` has no effect on either output.
- R10: With `mode16_i`=0, `cond_branch_o`=0 whatever the instruction bits.
- R11: For each m from 0 to 6, codes 2m and 2m+1 give opposite results under the same flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode16_i | input | 1 | 1 selects the 16-bit encoding, 0 the 32-bit one |
| instr_i | input | 32 | Instruction word; only the low halfword is used in 16-bit mode |
| flags_i | input | 4 | Status flags {N,Z,C,V} |
| pass_o | output | 1 | Instruction may execute |
| cond_branch_o | output | 1 | Word is a 16-bit conditional branch |

## Verification
Every code is exercised against all sixteen flag combinations in both encodings. This exposes a swapped flag, which would flip the result for exactly half the flag patterns of the code that tests it. It also exposes a wrong compound term for the codes 8 to 13, such as AND used in place of OR. Random filler in the unused instruction bits catches a field taken from the wrong nibble, which would make the result follow noise. Narrow words with every top nibble other than 0xD catch a branch detector that matches too broadly: such a design would suppress ordinary 16-bit instructions. Wide words that carry 0xD at bits 15:12 catch a branch flag that leaks into wide mode.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic cond_holds(logic [CODE_W-1:0] code, flags_t f);
    logic r;
    case (code)
      4'h0:    r = f.z;
      4'h1:    r = !f.z;
      4'h2:    r = f.c;
      4'h3:    r = !f.c;
      4'h4:    r = f.n;
      4'h5:    r = !f.n;
      4'h6:    r = f.v;
      4'h7:    r = !f.v;
      4'h8:    r = f.c && !f.z;
      4'h9:    r = !f.c || f.z;
      4'hA:    r = (f.n == f.v);
      4'hB:    r = (f.n != f.v);
      4'hC:    r = !f.z && (f.n == f.v);
      4'hD:    r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cond_field_sel.sv
module cond_field_sel
  import cond_eval_pkg::*;
#(
  parameter int          INSTR_W  = 32,
  parameter int          NARROW_W = 16,
  parameter logic [3:0]  BR_MARK  = 4'hD
) (
  input  logic               mode16_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               cond_branch_o,
  output logic               bypass_o
);
  localparam int WIDE_LSB   = INSTR_W - CODE_W;
  localparam int MARK_LSB   = NARROW_W - CODE_W;
  localparam int NARROW_LSB = MARK_LSB - CODE_W;

  logic [CODE_W-1:0] mark;
  logic              is_br;
  logic              unused_bits;

  assign mark        = instr_i[MARK_LSB +: CODE_W];
  assign is_br       = (mark == BR_MARK);
  assign unused_bits = ^instr_i[NARROW_LSB-1:0];

  always_comb begin
    if (mode16_i) begin
      code_o        = instr_i[NARROW_LSB +: CODE_W];
      cond_branch_o = is_br;
      bypass_o      = !is_br;
    end else begin
      code_o        = instr_i[WIDE_LSB +: CODE_W];
      cond_branch_o = 1'b0;
      bypass_o      = 1'b0;
    end
  end
endmodule

// File: rtl/cond_table.sv
module cond_table
  import cond_eval_pkg::*;
(
  input  flags_t               flags_i,
  output logic [NUM_CODES-1:0] hold_o
);
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    assign hold_o[k] = cond_holds(CODE_W'(k), flags_i);
  end

  always_comb begin
    for (int m = 0; m < NUM_CODES/2 - 1; m++) begin
      AST_PAIR_COMPLEMENT: assert (hold_o[2*m] != hold_o[2*m+1])  // R11
        else $error("pair %0d not complementary", m);
    end
    AST_ALWAYS_PAIR: assert (hold_o[14] && hold_o[15]) else $error("always codes failed");  // R6
    AST_GT_WITHIN_GE: assert (!hold_o[12] || hold_o[10]) else $error("12 without 10");       // R5
    AST_HI_EXCLUDES_EQ: assert (!hold_o[8] || !hold_o[0]) else $error("8 with Z set");       // R3
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int NARROW_W = 16
) (
  input  logic               mode16_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [3:0]         flags_i,
  output logic               pass_o,
  output logic               cond_branch_o
);
  logic [CODE_W-1:0]    code;
  logic                 bypass;
  logic [NUM_CODES-1:0] hold;

  cond_field_sel #(
    .INSTR_W (INSTR_W),
    .NARROW_W(NARROW_W),
    .BR_MARK (4'hD)
  ) u_sel (
    .mode16_i     (mode16_i),
    .instr_i      (instr_i),
    .code_o       (code),
    .cond_branch_o(cond_branch_o),
    .bypass_o     (bypass)
  );

  cond_table u_tab (
    .flags_i(flags_t'(flags_i)),
    .hold_o (hold)
  );

  assign pass_o = bypass || hold[code];

  always_comb begin
    if (mode16_i && !cond_branch_o)
      AST_NARROW_BYPASS: assert (pass_o) else $error("narrow non-branch blocked");  // R8
    if (!mode16_i)
      AST_WIDE_NO_BRANCH: assert (!cond_branch_o) else $error("branch flag in wide mode");  // R10
  end
endmodule

// File: tb/cond_eval_tb_top.sv
module cond_eval_tb_top;
  typedef struct {
    logic  ep;
    logic  eb;
    string tag;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode16;
  logic [31:0] instr;
  logic [3:0]  flags;
  logic        pass_w, br_w;
  item_t       q[$];
  int          checks = 0, fails = 0, cycles = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  cond_eval dut_i (
    .mode16_i(mode16), .instr_i(instr), .flags_i(flags),
    .pass_o(pass_w), .cond_branch_o(br_w)
  );

  function automatic logic ref_pass(logic [3:0] code, logic [3:0] f);
    logic n, z, c, v, base;
    {n, z, c, v} = f;
    case (code[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return (code[3:1] == 3'd7) ? 1'b1 : (base ^ code[0]);
  endfunction

  function automatic string tag_of(logic [3:0] code);
    if (code < 8)  return "R2";
    if (code < 10) return "R3";
    if (code < 12) return "R4";
    if (code < 14) return "R5";
    return "R6";
  endfunction

  task automatic drive(logic m, logic [31:0] ins, logic [3:0] f, logic ep, logic eb, string tag);
    item_t it;
    @(posedge clk);
    #1;
    mode16 = m; instr = ins; flags = f;
    it.ep = ep; it.eb = eb; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pass_w !== it.ep) begin
        fails++;
        $display("FAIL %s pass_o actual=%b expected=%b", it.tag, pass_w, it.ep);
      end
      checks++;
      if (br_w !== it.eb) begin
        fails++;
        $display("FAIL %s cond_branch_o actual=%b expected=%b", it.tag, br_w, it.eb);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mode16 = 0; instr = '0; flags = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // reset-state pattern: code 0 with Z clear (R2)
    drive(0, 32'h0, 4'h0, 1'b0, 1'b0, "R2");
    // wide mode sweep with low-bit noise (R1..R6, R10)
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        logic [31:0] w;
        w = {c[3:0], 28'($urandom)};
        drive(0, w, f[3:0], ref_pass(c[3:0], f[3:0]), 1'b0, tag_of(c[3:0]));
      end
    // R1: same code, different low bits
    drive(0, 32'h0FFF_FFFF, 4'b0100, 1'b1, 1'b0, "R1");
    drive(0, 32'h0000_0000, 4'b0100, 1'b1, 1'b0, "R1");
    // R10: wide word carrying the branch mark in bits 15:12
    drive(0, 32'h1000_D000, 4'b0100, 1'b0, 1'b0, "R10");
    drive(0, 32'hE000_DE00, 4'b0000, 1'b1, 1'b0, "R10");
    // narrow branch sweep with upper-half noise (R7, R9)
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        logic [31:0] w;
        w = {16'($urandom), 4'hD, c[3:0], 8'($urandom)};
        drive(1, w, f[3:0], ref_pass(c[3:0], f[3:0]), 1'b1, "R7");
      end
    // R9: upper half must not matter
    drive(1, 32'hFFFF_D1AA, 4'b0100, 1'b0, 1'b1, "R9");
    drive(1, 32'h0000_D1AA, 4'b0100, 1'b0, 1'b1, "R9");
    drive(1, 32'hD000_1000, 4'b0000, 1'b1, 1'b0, "R9");
    // R8: every non-branch top nibble, hostile condition bits
    for (int t = 0; t < 16; t++) begin
      if (t == 13) continue;
      for (int f = 0; f < 16; f += 5)
        drive(1, {16'($urandom), t[3:0], 4'h0, 8'($urandom)}, f[3:0], 1'b1, 1'b0, "R8");
    end
    // R11: odd code is the complement of its even partner
    for (int m = 0; m < 7; m++)
      for (int f = 0; f < 16; f++)
        drive(0, {4'(2*m+1), 28'h0}, f[3:0], ~ref_pass(4'(2*m), f[3:0]), 1'b0, "R11");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule